// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches recent virtual-to-physical page translations. A 31-bit virtual address arrives on the lookup port. Its upper 19 bits, the virtual page number, are compared against every stored entry in the same cycle. On a match, the block returns a 27-bit physical address. That address is the stored 15-bit physical page number placed above the untouched 12-bit page offset.

When no entry matches, the block raises a walk request so that an outside agent can read the page table. The agent then writes the resulting pair back through the fill port. Each fill follows a fixed placement order:

- a fill whose virtual page is already present overwrites that entry;
- otherwise the lowest-numbered empty entry is used;
- otherwise a round-robin pointer picks the entry to evict.

A flush input empties the whole buffer in one cycle. The entry count is a parameter. It defaults to two and also suits 8 or 16.

Top module: `tlb_xlate`

## Requirements
- R1: While `lookup_en` is high and a valid entry holds the virtual page number `lookup_va[30:12]`, `lookup_hit` is 1 in the same cycle and `lookup_pa` equals {stored physical page number, `lookup_va[11:0]`}. Example: with entries 0x7FFFD→0x0000 and 0x00002→0x7FFF, address 0x247C gives 0x7FFF47C.
- R2: While `lookup_en` is high and no valid entry matches, `walk_req` is 1 and `lookup_hit` is 0. While `lookup_en` is low, both are 0. The two are never high together.
- R3: A fill presented at a clock edge without flush is visible to lookups from the next cycle on, as a valid entry.
- R4: A fill whose page is not present, while an empty entry exists, writes the lowest-numbered empty entry and leaves the eviction pointer unchanged.
- R5: A fill whose page is not present, with every entry valid, replaces the entry named by the eviction pointer. The pointer then advances by one and wraps from the last entry to entry 0.
- R6: A fill whose virtual page number is already held by a valid entry overwrites that entry's physical page number, and the eviction pointer does not move.
- R7: Flush empties every entry and returns the eviction pointer to entry 0 at the next edge. A fill in the same cycle as a flush is dropped.
- R8: After reset every entry is empty and the eviction pointer is at entry 0.
- R9: No two valid entries ever hold the same virtual page number, so at most one entry matches a lookup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lookup_en | input | 1 | A lookup is presented this cycle |
| lookup_va | input | 31 | Virtual address to translate |
| lookup_hit | output | 1 | Translation found |
| lookup_pa | output | 27 | Translated physical address, meaningful only with hit |
| walk_req | output | 1 | Lookup missed; page-table read needed |
| fill_en | input | 1 | Write a translation at this edge |
| fill_vpn | input | 19 | Virtual page number to store |
| fill_ppn | input | 15 | Physical page number to store |
| flush_en | input | 1 | Empty the buffer at this edge |

## Verification
Lookup results are combinational, so `lookup_hit`, `walk_req` and `lookup_pa` are due in the cycle the address is driven. The bench samples them one nanosecond after driving, well before the next edge. Fills and flushes land at the following rising edge, so their effect is checked by lookups in the cycle after that edge.

Placement order (duplicate, empty, pointer) and pointer movement are not visible directly. The bench shows them by filling enough pages to force evictions and then checking which older pages still hit. A behavioural model of the entries is updated at every edge and compared with the outputs on every cycle, through both a directed sequence and a random phase.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VPN_BITS    = 19;
    localparam int PPN_BITS    = 15;
    localparam int OFFSET_BITS = 12;
    localparam int DEF_ENTRIES = 2;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int N  = 2,
    parameter int KW = 19
) (
    input  logic [N-1:0]         vld,
    input  logic [N-1:0][KW-1:0] keys,
    input  logic [KW-1:0]        probe,
    output logic [N-1:0]         match
);
    // one comparator per entry, all evaluated together
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = vld[g] && (keys[g] == probe);
    end
endmodule

// File: rtl/tlb_sel.sv
module tlb_sel #(
    parameter int N = 2,
    parameter int W = 15
) (
    input  logic [N-1:0]        sel,
    input  logic [N-1:0][W-1:0] data,
    output logic [W-1:0]        out
);
    // AND-OR mux; sel is at most one-hot, zero when nothing selected
    always_comb begin
        out = '0;
        for (int i = 0; i < N; i++) begin
            out = out | (data[i] & {W{sel[i]}});
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N  = 2,
    parameter int PW = 1
) (
    input  logic [N-1:0]  vld,
    input  logic [N-1:0]  dup_vec,
    input  logic          dup_any,
    input  logic [PW-1:0] ptr,
    output logic [N-1:0]  wr_vec,
    output logic          use_ptr
);
    logic [N-1:0] free_vec;
    logic         free_any;
    logic [N-1:0] ptr_vec;

    // lowest-numbered empty entry
    always_comb begin
        free_vec = '0;
        free_any = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!vld[i] && !free_any) begin
                free_vec[i] = 1'b1;
                free_any    = 1'b1;
            end
        end
    end

    always_comb begin
        ptr_vec = '0;
        for (int i = 0; i < N; i++) begin
            if (ptr == PW'(i)) ptr_vec[i] = 1'b1;
        end
    end

    // priority: existing page, then empty slot, then round-robin pointer
    always_comb begin
        use_ptr = 1'b0;
        if (dup_any) begin
            wr_vec = dup_vec;
        end else if (free_any) begin
            wr_vec = free_vec;
        end else begin
            wr_vec  = ptr_vec;
            use_ptr = 1'b1;
        end
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
    parameter int ENTRIES = tlb_pkg::DEF_ENTRIES,
    parameter int VPN_W   = tlb_pkg::VPN_BITS,
    parameter int PPN_W   = tlb_pkg::PPN_BITS,
    parameter int OFF_W   = tlb_pkg::OFFSET_BITS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lookup_en,
    input  logic [VPN_W+OFF_W-1:0] lookup_va,
    output logic                   lookup_hit,
    output logic [PPN_W+OFF_W-1:0] lookup_pa,
    output logic                   walk_req,
    input  logic                   fill_en,
    input  logic [VPN_W-1:0]       fill_vpn,
    input  logic [PPN_W-1:0]       fill_ppn,
    input  logic                   flush_en
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0]            vld;
        logic [ENTRIES-1:0][VPN_W-1:0] vpn;
        logic [ENTRIES-1:0][PPN_W-1:0] ppn;
        logic [PTR_W-1:0]              ptr;
    } tlb_state_t;

    tlb_state_t s_q, s_d;

    logic [VPN_W-1:0]   lk_vpn;
    logic [OFF_W-1:0]   lk_off;
    logic [ENTRIES-1:0] lk_match;
    logic [PPN_W-1:0]   lk_ppn;
    logic [ENTRIES-1:0] fl_match;
    logic [ENTRIES-1:0] wr_vec;
    logic               use_ptr;

    assign lk_vpn = lookup_va[VPN_W+OFF_W-1:OFF_W];
    assign lk_off = lookup_va[OFF_W-1:0];

    tlb_cam #(.N(ENTRIES), .KW(VPN_W)) u_lk_cam (
        .vld   (s_q.vld),
        .keys  (s_q.vpn),
        .probe (lk_vpn),
        .match (lk_match)
    );

    tlb_sel #(.N(ENTRIES), .W(PPN_W)) u_lk_sel (
        .sel  (lk_match),
        .data (s_q.ppn),
        .out  (lk_ppn)
    );

    tlb_cam #(.N(ENTRIES), .KW(VPN_W)) u_fl_cam (
        .vld   (s_q.vld),
        .keys  (s_q.vpn),
        .probe (fill_vpn),
        .match (fl_match)
    );

    tlb_victim #(.N(ENTRIES), .PW(PTR_W)) u_victim (
        .vld     (s_q.vld),
        .dup_vec (fl_match),
        .dup_any (|fl_match),
        .ptr     (s_q.ptr),
        .wr_vec  (wr_vec),
        .use_ptr (use_ptr)
    );

    assign lookup_hit = lookup_en && (|lk_match);
    assign walk_req   = lookup_en && !(|lk_match);
    assign lookup_pa  = {lk_ppn, lk_off};

    always_comb begin
        s_d = s_q;
        if (flush_en) begin
            s_d.vld = '0;
            s_d.ptr = '0;
        end else if (fill_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (wr_vec[i]) begin
                    s_d.vld[i] = 1'b1;
                    s_d.vpn[i] = fill_vpn;
                    s_d.ppn[i] = fill_ppn;
                end
            end
            if (use_ptr) begin
                s_d.ptr = (s_q.ptr == PTR_LAST) ? '0 : s_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
    parameter int N     = 2,
    parameter int VPN_W = 19,
    parameter int PPN_W = 15,
    parameter int OFF_W = 12,
    parameter int PTR_W = 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   lookup_en,
    input logic [VPN_W+OFF_W-1:0] lookup_va,
    input logic                   lookup_hit,
    input logic [PPN_W+OFF_W-1:0] lookup_pa,
    input logic                   walk_req,
    input logic                   fill_en,
    input logic [VPN_W-1:0]       fill_vpn,
    input logic                   flush_en,
    input logic [N-1:0]           lk_match,
    input logic [N-1:0]           vld_q,
    input logic [N-1:0][VPN_W-1:0] vpn_q,
    input logic [PTR_W-1:0]       ptr_q
);
    logic [VPN_W-1:0] last_fill_vpn;
    logic             fill_present;
    logic             fill_dup_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_fill_vpn <= '0;
        else        last_fill_vpn <= fill_vpn;
    end

    always_comb begin
        fill_present = 1'b0;
        fill_dup_now = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (vld_q[i] && vpn_q[i] == last_fill_vpn) fill_present = 1'b1;
            if (vld_q[i] && vpn_q[i] == fill_vpn)      fill_dup_now = 1'b1;
        end
    end

    assert_hit_walk_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(lookup_hit && walk_req));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_en |-> (!lookup_hit && !walk_req));

    assert_single_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_hit |-> (lookup_pa[OFF_W-1:0] == lookup_va[OFF_W-1:0]));

    assert_fill_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush_en) |=> fill_present);

    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_en |=> (vld_q == '0 && ptr_q == '0));

    assert_ptr_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((N > 1) && fill_en && !flush_en && (&vld_q) && !fill_dup_now)
            |=> (ptr_q != $past(ptr_q)));
endmodule

bind tlb_xlate tlb_xlate_chk #(
    .N(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W), .PTR_W(PTR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lookup_en  (lookup_en),
    .lookup_va  (lookup_va),
    .lookup_hit (lookup_hit),
    .lookup_pa  (lookup_pa),
    .walk_req   (walk_req),
    .fill_en    (fill_en),
    .fill_vpn   (fill_vpn),
    .flush_en   (flush_en),
    .lk_match   (lk_match),
    .vld_q      (s_q.vld),
    .vpn_q      (s_q.vpn),
    .ptr_q      (s_q.ptr)
);

// File: tb/tlb_xlate_test.sv
`timescale 1ns/1ps
module tlb_xlate_test;
    localparam int N = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lookup_en = 1'b0;
    logic [30:0] lookup_va = '0;
    logic        lookup_hit;
    logic [26:0] lookup_pa;
    logic        walk_req;
    logic        fill_en = 1'b0;
    logic [18:0] fill_vpn = '0;
    logic [14:0] fill_ppn = '0;
    logic        flush_en = 1'b0;

    int total = 0;
    int bad = 0;

    int m_vld[N];
    int m_vpn[N];
    int m_ppn[N];
    int m_ptr;

    always #2 clk = ~clk;

    tlb_xlate #(.ENTRIES(N)) uut (
        .clk(clk), .rst_n(rst_n), .lookup_en(lookup_en), .lookup_va(lookup_va),
        .lookup_hit(lookup_hit), .lookup_pa(lookup_pa), .walk_req(walk_req),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .flush_en(flush_en)
    );

    task automatic chk(string tag, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0;
        end
        m_ptr = 0;
    endtask

    task automatic model_edge();
        int slot;
        if (flush_en) begin
            model_reset();
        end else if (fill_en) begin
            slot = -1;
            for (int i = 0; i < N; i++)
                if (m_vld[i] != 0 && m_vpn[i] == int'(fill_vpn)) slot = i;
            if (slot < 0)
                for (int i = N - 1; i >= 0; i--)
                    if (m_vld[i] == 0) slot = i;
            if (slot < 0) begin
                slot = m_ptr;
                m_ptr = (m_ptr + 1) % N;
            end
            m_vld[slot] = 1;
            m_vpn[slot] = int'(fill_vpn);
            m_ppn[slot] = int'(fill_ppn);
        end
    endtask

    // compare with the model, then take the edge
    task automatic tick();
        int eh;
        longint epa;
        #1;
        eh = 0; epa = 0;
        for (int i = 0; i < N; i++)
            if (lookup_en && m_vld[i] != 0 && m_vpn[i] == int'(lookup_va[30:12])) begin
                eh = 1;
                epa = (longint'(m_ppn[i]) << 12) | longint'(lookup_va[11:0]);
            end
        chk("R1 model hit", lookup_hit, eh);
        chk("R2 model walk", walk_req, (lookup_en && eh == 0) ? 1 : 0);
        if (eh != 0) chk("R1 model pa", lookup_pa, epa);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        fill_en = 1'b0; flush_en = 1'b0; lookup_en = 1'b0;
    endtask

    task automatic look(string tag, logic [30:0] va, int eh, longint epa);
        lookup_en = 1'b1; lookup_va = va;
        #1;
        chk({tag, " hit"}, lookup_hit, eh);
        chk({tag, " walk"}, walk_req, eh == 0 ? 1 : 0);
        if (eh != 0) chk({tag, " pa"}, lookup_pa, epa);
        tick();
    endtask

    task automatic fill(logic [18:0] v, logic [14:0] p, logic fl);
        fill_en = 1'b1; fill_vpn = v; fill_ppn = p; flush_en = fl;
        tick();
    endtask

    initial begin
        #(200000 * 4);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        look("R8 empty after reset", 31'h247C, 0, 0);
        lookup_en = 1'b0; lookup_va = 31'h247C; #1;
        chk("R2 idle hit", lookup_hit, 0);
        chk("R2 idle walk", walk_req, 0);
        tick();

        fill(19'h7FFFD, 15'h0000, 1'b0);
        fill(19'h00002, 15'h7FFF, 1'b0);
        look("R1 example", 31'h247C, 1, 27'h7FFF47C);
        look("R3 first fill", {19'h7FFFD, 12'h123}, 1, 27'h0000123);

        fill(19'h00005, 15'h0001, 1'b0);              // evicts entry 0
        look("R5 evicted at ptr 0", {19'h7FFFD, 12'h123}, 0, 0);
        look("R3 new page", 31'h5F20, 1, 27'h0001F20);
        look("R5 entry 1 kept", 31'h247C, 1, 27'h7FFF47C);

        fill(19'h00007, 15'h1234, 1'b0);              // evicts entry 1, wraps
        look("R5 wrap evicts entry 1", 31'h247C, 0, 0);

        fill(19'h00005, 15'h0AAA, 1'b0);              // duplicate page
        look("R6 overwrite", 31'h5F20, 1, 27'h0AAAF20);
        look("R6 other kept", 31'h73E0, 1, 27'h12343E0);

        fill(19'h00009, 15'h0055, 1'b0);              // pointer still 0
        look("R6 ptr unmoved evicts dup slot", 31'h5F20, 0, 0);
        look("R6 ptr unmoved keeps entry 1", 31'h73E0, 1, 27'h12343E0);

        fill(19'h00000, 15'h0000, 1'b1);              // flush
        look("R7 flushed a", 31'h73E0, 0, 0);
        look("R7 flushed b", 31'h9000, 0, 0);

        fill(19'h00003, 15'h0003, 1'b1);              // fill with flush
        look("R7 fill dropped", 31'h3000, 0, 0);

        fill(19'h00011, 15'h0011, 1'b0);
        fill(19'h00012, 15'h0012, 1'b0);
        look("R4 first empty a", 31'h11000, 1, 27'h0011000);
        look("R4 first empty b", 31'h12000, 1, 27'h0012000);
        fill(19'h00013, 15'h0013, 1'b0);
        look("R7 ptr back to 0", 31'h11000, 0, 0);
        look("R4 ptr unmoved by empty fills", 31'h12000, 1, 27'h0012000);

        // random traffic, model compared every cycle (R9 via small page space)
        for (int k = 0; k < 600; k++) begin
            lookup_en = 1'($urandom_range(0, 3) != 0);
            lookup_va = {19'($urandom_range(0, 5)), 12'($urandom)};
            fill_en   = 1'($urandom_range(0, 9) < 3);
            fill_vpn  = 19'($urandom_range(0, 5));
            fill_ppn  = 15'($urandom);
            flush_en  = 1'($urandom_range(0, 49) == 0);
            tick();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule